// File: doc/BRIEF.md
# Three-Lane Serial Acquisition Frame Sequencer

This block is the digital control core of a three-channel data acquisition front end. A conversion request starts a fixed frame of fourteen clock edges. Across that frame the core sends three 12-bit result words at once, each on its own serial line, and takes in a 13-bit setup word on one serial input. It also produces a busy flag and a gated data clock for the receiving processor. The core never touches the analog side: result words arrive as parallel inputs, and the core drives the DAC code, gain select and channel select as registered outputs.

The setup word is double-buffered, and its fields take effect at different times. The DAC code is copied to its output on the last edge of the frame that carried it. The gain and channel fields wait in a pending register and only reach their outputs when the next conversion starts. Analog settings therefore never change during a conversion.

The controller has two states. In `ST_IDLE`, transition *start* is taken when `conv_req` is high at a clock edge. In `ST_FRAME`, a position counter runs from 1 to 13. Transition *advance* is taken below 13, and transition *close* returns to `ST_IDLE` at position 13. The frame edges are numbered 1 (the start edge) through 14 (the close edge).

Top module: `acq_frame_seq`

## Requirements
- R1: Reset, asynchronous and active low, clears `busy`, `dclk_out`, `ser_out`, `dac_code`, `gain_sel`, `chan_sel` and the pending setup fields to zero.
- R2: With the core idle, a clock edge with `conv_req` high is frame edge 1. `busy` is high after edges 1 to 13 and low again after edge 14.
- R3: `conv_req` is ignored while `busy` is high. A frame with `conv_req` held high keeps exactly the timing of R2.
- R4: Lane i sends `res_words[i*12 +: 12]`, sampled at edge 1, MSB first. Result bit 11-j appears on `ser_out[i]` after edge j+2 (j = 0..11). All lanes move together, and `ser_out` is 0 at every other time.
- R5: `dclk_out` follows `clk` only in the cycles after edges 2 to 13, giving twelve pulses that match the result bits. At all other times it is low.
- R6: `ser_in` is sampled at edges 2 to 14, giving bits w[12] down to w[0] in that order. The DAC code is w[12:5] (MSB first), the gain select is w[4:3] and the channel select is w[2:0].
- R7: `dac_code` takes w[12:5] at edge 14 of the frame that carried it and holds its value at every other edge.
- R8: `gain_sel` and `chan_sel` change only at edge 1 of a conversion. They load the fields of the most recently completed setup word, which is zero if no frame has completed since reset.
- R9: Changes on `res_words` after edge 1 do not change the bits being sent in that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External conversion clock; may stop between frames |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_req | input | 1 | Conversion request |
| res_words | input | 36 | Three parallel 12-bit result words, lane 0 in the low bits |
| ser_in | input | 1 | Serial setup word input |
| busy | output | 1 | Frame in progress |
| dclk_out | output | 1 | Gated data clock for the result lines |
| ser_out | output | 3 | Serial result lines, one per lane |
| dac_code | output | 8 | Latched DAC code |
| gain_sel | output | 2 | Active gain select |
| chan_sel | output | 3 | Active channel select |

## Verification
Every output is fixed by the number of edges since frame edge 1. `busy` is due after edge 1 and clears after edge 14. Result bit j and its data clock pulse are due after edge j+2, the DAC code after edge 14, and the gain and channel fields after edge 1 of the following frame. The driver drives inputs at falling edges and queues one expected record per rising edge. The monitor pops and compares that record 1 ns after the rising edge, while `clk` is high, so the gated clock can be seen and no sample falls on an edge. Frames are run with `conv_req` held through the whole frame, with result inputs scrambled after edge 1, and across a mid-run reset.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;

    // Controller states: waiting for a request, or inside a frame
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_FRAME = 1'b1
    } seq_state_t;

endpackage

// File: rtl/acq_frame_ctrl.sv
module acq_frame_ctrl
    import acq_seq_pkg::*;
#(
    parameter int RES_W = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic conv_req,
    output logic busy,
    output logic load_en,
    output logic shift_en,
    output logic out_en,
    output logic sample_en,
    output logic commit_en
);

    // Positions 1..LAST_POS are held in ST_FRAME; the close edge is LAST_POS+1
    localparam int LAST_POS = RES_W + 1;
    localparam int POS_W    = $clog2(LAST_POS + 1);
    localparam logic [POS_W-1:0] POS_LAST  = POS_W'(LAST_POS);
    localparam logic [POS_W-1:0] POS_FIRST = POS_W'(1);
    localparam logic [POS_W-1:0] POS_OUT   = POS_W'(2);
    localparam logic [POS_W-1:0] POS_SHEND = POS_W'(RES_W);

    seq_state_t       state_q, state_d;
    logic [POS_W-1:0] pos_q, pos_d;

    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        unique case (state_q)
            ST_IDLE: begin
                if (conv_req) begin          // start
                    state_d = ST_FRAME;
                    pos_d   = POS_FIRST;
                end
            end
            ST_FRAME: begin
                if (pos_q == POS_LAST) begin // close
                    state_d = ST_IDLE;
                    pos_d   = '0;
                end else begin               // advance
                    pos_d   = pos_q + POS_W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pos_q   <= '0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
        end
    end

    always_comb begin
        busy      = (state_q == ST_FRAME);
        load_en   = (state_q == ST_IDLE) && conv_req;
        out_en    = (state_q == ST_FRAME) && (pos_q >= POS_OUT);
        shift_en  = (state_q == ST_FRAME) && (pos_q >= POS_OUT) && (pos_q <= POS_SHEND);
        sample_en = (state_q == ST_FRAME);
        commit_en = (state_q == ST_FRAME) && (pos_q == POS_LAST);
    end

    AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FRAME && pos_q != POS_LAST) |=> (state_q == ST_FRAME && pos_q == $past(pos_q) + POS_W'(1))); // R2
    AST_FRAME_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |=> !busy); // R2
    AST_CONV_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && conv_req && !commit_en) |=> (busy && !load_en)); // R3

endmodule

// File: rtl/acq_result_lanes.sv
module acq_result_lanes #(
    parameter int LANES = 3,
    parameter int RES_W = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_en,
    input  logic                   shift_en,
    input  logic                   out_en,
    input  logic [LANES*RES_W-1:0] res_words,
    output logic [LANES-1:0]       ser_out
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [RES_W-1:0] sh_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sh_q <= '0;
            end else if (load_en) begin
                sh_q <= res_words[g*RES_W +: RES_W];
            end else if (shift_en) begin
                sh_q <= {sh_q[RES_W-2:0], 1'b0};
            end
        end

        assign ser_out[g] = out_en & sh_q[RES_W-1];
    end

    AST_LOAD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (ser_out == '0)); // R4

endmodule

// File: rtl/acq_setup_rx.sv
module acq_setup_rx #(
    parameter int DAC_W  = 8,
    parameter int GAIN_W = 2,
    parameter int CHAN_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_in,
    input  logic              sample_en,
    input  logic              commit_en,
    input  logic              load_en,
    output logic [DAC_W-1:0]  dac_code,
    output logic [GAIN_W-1:0] gain_sel,
    output logic [CHAN_W-1:0] chan_sel
);

    localparam int SETUP_W = DAC_W + GAIN_W + CHAN_W;

    logic [SETUP_W-2:0]  rx_q;
    logic [SETUP_W-1:0]  word;
    logic [GAIN_W-1:0]   pend_gain_q;
    logic [CHAN_W-1:0]   pend_chan_q;

    // Word as it stands once the last serial bit is present
    assign word = {rx_q, ser_in};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (sample_en) begin
            rx_q <= word[SETUP_W-2:0];
        end
    end

    // First buffer stage: commit at the frame's close edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dac_code    <= '0;
            pend_gain_q <= '0;
            pend_chan_q <= '0;
        end else if (commit_en) begin
            dac_code    <= word[SETUP_W-1 -: DAC_W];
            pend_gain_q <= word[CHAN_W +: GAIN_W];
            pend_chan_q <= word[CHAN_W-1:0];
        end
    end

    // Second buffer stage: apply at the start of the next conversion
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gain_sel <= '0;
            chan_sel <= '0;
        end else if (load_en) begin
            gain_sel <= pend_gain_q;
            chan_sel <= pend_chan_q;
        end
    end

    AST_DAC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_en |=> $stable(dac_code)); // R7
    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> ($stable(gain_sel) && $stable(chan_sel))); // R8

endmodule

// File: rtl/acq_frame_seq.sv
module acq_frame_seq #(
    parameter int LANES  = 3,
    parameter int RES_W  = 12,
    parameter int DAC_W  = 8,
    parameter int GAIN_W = 2,
    parameter int CHAN_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   conv_req,
    input  logic [LANES*RES_W-1:0] res_words,
    input  logic                   ser_in,
    output logic                   busy,
    output logic                   dclk_out,
    output logic [LANES-1:0]       ser_out,
    output logic [DAC_W-1:0]       dac_code,
    output logic [GAIN_W-1:0]      gain_sel,
    output logic [CHAN_W-1:0]      chan_sel
);

    logic load_en, shift_en, out_en, sample_en, commit_en;

    acq_frame_ctrl #(.RES_W(RES_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .conv_req (conv_req),
        .busy     (busy),
        .load_en  (load_en),
        .shift_en (shift_en),
        .out_en   (out_en),
        .sample_en(sample_en),
        .commit_en(commit_en)
    );

    acq_result_lanes #(.LANES(LANES), .RES_W(RES_W)) u_lanes (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .shift_en (shift_en),
        .out_en   (out_en),
        .res_words(res_words),
        .ser_out  (ser_out)
    );

    acq_setup_rx #(.DAC_W(DAC_W), .GAIN_W(GAIN_W), .CHAN_W(CHAN_W)) u_setup (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_in   (ser_in),
        .sample_en(sample_en),
        .commit_en(commit_en),
        .load_en  (load_en),
        .dac_code (dac_code),
        .gain_sel (gain_sel),
        .chan_sel (chan_sel)
    );

    // Data clock passes only while result bits are on the lines
    assign dclk_out = clk & out_en;

    AST_DCLK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        out_en |-> busy); // R5
    AST_IDLE_LINES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ser_out == '0)); // R4

endmodule

// File: tb/acq_frame_seq_tb.sv
module acq_frame_seq_tb;

    logic        clk;
    logic        rst_n;
    logic        conv_req;
    logic [35:0] res_words;
    logic        ser_in;
    logic        busy;
    logic        dclk_out;
    logic [2:0]  ser_out;
    logic [7:0]  dac_code;
    logic [1:0]  gain_sel;
    logic [2:0]  chan_sel;

    acq_frame_seq u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .conv_req (conv_req),
        .res_words(res_words),
        .ser_in   (ser_in),
        .busy     (busy),
        .dclk_out (dclk_out),
        .ser_out  (ser_out),
        .dac_code (dac_code),
        .gain_sel (gain_sel),
        .chan_sel (chan_sel)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    typedef struct {
        int         k;
        logic       busy;
        logic       dclk;
        logic [2:0] so;
        logic [7:0] dac;
        logic [1:0] gain;
        logic [2:0] chan;
    } exp_t;

    exp_t q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    logic [7:0] exp_dac;
    logic [1:0] exp_gain, pend_gain;
    logic [2:0] exp_chan, pend_chan;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: one expected record per rising edge, compared with clk high
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check("R2/R3", $sformatf("busy after edge %0d", e.k), busy, e.busy);
                check("R5", $sformatf("dclk_out after edge %0d", e.k), dclk_out, e.dclk);
                check("R4/R9", $sformatf("ser_out after edge %0d", e.k), ser_out, e.so);
                check("R7/R6", $sformatf("dac_code after edge %0d", e.k), dac_code, e.dac);
                check("R8/R6", $sformatf("gain_sel after edge %0d", e.k), gain_sel, e.gain);
                check("R8/R6", $sformatf("chan_sel after edge %0d", e.k), chan_sel, e.chan);
            end
        end
    end

    task automatic drain();
        while (q.size() != 0) @(posedge clk);
        #2;
    endtask

    // Driver: one full frame, edges 1..14 plus one idle edge
    task automatic run_frame(input logic [11:0] a, input logic [11:0] b, input logic [11:0] c,
                             input logic [12:0] word, input bit conv_hold);
        for (int k = 1; k <= 15; k++) begin
            exp_t e;
            @(negedge clk);
            if (k == 1) begin
                conv_req  = 1'b1;
                res_words = {c, b, a};
                ser_in    = 1'b0;
            end else if (k <= 14) begin
                conv_req  = conv_hold;               // R3: ignored while busy
                res_words = ~{c, b, a} ^ {3{12'(k * 37)}}; // R9: scrambled
                ser_in    = word[14 - k];
            end else begin
                conv_req  = 1'b0;
                ser_in    = 1'b0;
            end
            if (k == 1) begin
                exp_gain = pend_gain;
                exp_chan = pend_chan;
            end
            if (k == 14) begin
                exp_dac   = word[12:5];
                pend_gain = word[4:3];
                pend_chan = word[2:0];
            end
            e.k    = k;
            e.busy = (k <= 13);
            e.dclk = (k >= 2) && (k <= 13);
            e.so   = e.dclk ? {c[13 - k], b[13 - k], a[13 - k]} : 3'b000;
            e.dac  = exp_dac;
            e.gain = exp_gain;
            e.chan = exp_chan;
            q.push_back(e);
        end
        drain();
    endtask

    task automatic run_idle(input int n);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            @(negedge clk);
            conv_req = 1'b0;
            ser_in   = ~ser_in;
            e.k = 100 + i;
            e.busy = 1'b0;
            e.dclk = 1'b0;
            e.so   = 3'b000;
            e.dac  = exp_dac;
            e.gain = exp_gain;
            e.chan = exp_chan;
            q.push_back(e);
        end
        drain();
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        exp_dac = '0; exp_gain = '0; exp_chan = '0; pend_gain = '0; pend_chan = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1", "busy after reset", busy, 0);
        check("R1", "dclk_out after reset", dclk_out, 0);
        check("R1", "ser_out after reset", ser_out, 0);
        check("R1", "dac_code after reset", dac_code, 0);
        check("R1", "gain_sel after reset", gain_sel, 0);
        check("R1", "chan_sel after reset", chan_sel, 0);
    endtask

    initial begin
        rst_n = 1'b0;
        conv_req = 1'b0;
        res_words = '0;
        ser_in = 1'b0;
        exp_dac = '0; exp_gain = '0; exp_chan = '0; pend_gain = '0; pend_chan = '0;
        apply_reset();
        // Frame A: gain/chan still zero, DAC becomes C3 at edge 14
        run_frame(12'hA5C, 12'h3F0, 12'h801, {8'hC3, 2'b10, 3'b101}, 1'b0);
        // Frame B: conv_req held high all frame, A's selections apply
        run_frame(12'hFFF, 12'h000, 12'h555, {8'h5A, 2'b01, 3'b011}, 1'b1);
        run_idle(4);
        // Frame C: extremes on lanes and word
        run_frame(12'h001, 12'h800, 12'hC3C, {8'hFF, 2'b11, 3'b111}, 1'b0);
        // Reset clears everything, including the pending fields
        apply_reset();
        run_frame(12'h123, 12'h456, 12'h789, {8'h81, 2'b00, 3'b110}, 1'b0);
        run_frame(12'hE0F, 12'h70E, 12'h0F0, {8'h01, 2'b11, 3'b000}, 1'b0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule